// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32-row, two-colour hardware cursor over a streaming pixel path. For each incoming pixel it takes the pixel's coordinates and base 24-bit colour. If the pixel falls inside the cursor window and the cursor's shape bit for that spot is set, the block replaces the colour with one of two cursor colours. These two colours come from an external palette. All other pixels pass through unchanged. The result, together with the pixel's valid flag and coordinates, leaves the block exactly one clock later.

Software programs the cursor through a 32-bit word-addressed register port. The port holds a packed position word, one shape-mask word and one colour-select word for each cursor row, and a general-purpose misc word. Position and row words are staged and become active only on a frame-start pulse, so a frame never shows a half-updated cursor. After reset the cursor sits at a coordinate far outside any real screen.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `out_valid` and `reg_rdata` are 0, and both active cursor coordinates are 0xF000, so no pixel of an ordinary screen is overlaid even after a frame start.
- R2: A write to offset 0x8FC loads cursor X from write-data bits 31:16 and cursor Y from bits 15:0.
- R3: Writes in 0x900..0x97F set the shape-mask word of row (offset-0x900)>>2, and writes in 0x980..0x9FF set the colour-select word of row (offset-0x980)>>2.
- R4: Within a row, bit 31 of each word applies to cursor column 0 (pixel X equal to cursor X), and each later column uses the next lower bit.
- R5: Where the mask bit is 0 the base colour passes through; where it is 1 the output is `col_b` if the colour-select bit is 1 and `col_a` if it is 0.
- R6: Only lines with cursorY <= y < cursorY+32 are overlaid.
- R7: Nothing is overlaid when cursor X >= `active_width`, and cursor columns at x >= `active_width` are clipped (base colour kept).
- R8: A read of offset 0x818 returns the last value written there with bit 25 forced to 1. A read of any other offset returns 0. `reg_rdata` updates on the clock edge that samples `reg_rd_en`. Misc writes are visible at once.
- R9: `out_valid`, `out_x`, `out_y` and `out_color` are registered copies of the input pixel's valid, coordinates and overlay result, one cycle later. An input cycle with `pix_valid` low gives `out_valid` low.
- R10: Position and row-word writes have no effect on the overlay until the next clock edge with `frame_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| frame_start | input | 1 | Frame-start pulse that commits staged cursor state |
| active_width | input | 16 | Number of visible pixels per line |
| col_a | input | 24 | Cursor colour used where the colour-select bit is 0 |
| col_b | input | 24 | Cursor colour used where the colour-select bit is 1 |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel line |
| pix_color | input | 24 | Input base colour |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel line |
| out_color | output | 24 | Output colour after overlay |

## Verification
The bench keeps the default widths and offsets and the staged-update variant. It drives a 64x40 pixel screen with a 48-pixel active width, so every pixel of every frame can be swept and compared against an arithmetic model. This small screen brings into reach the cursor crossing the right clip edge and the bottom edge, a cursor placed entirely beyond the active width, the top-left corner placement and the parked reset position. Each of these is seen over whole frames, together with per-row mask and colour-select patterns that vary on every row.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;

   // Which source drives an output pixel
   typedef enum logic [1:0] {
      SRC_BASE  = 2'd0,
      SRC_COL_A = 2'd1,
      SRC_COL_B = 2'd2
   } pix_src_e;

   // Coordinate loaded at reset so the cursor lies outside any screen
   localparam int unsigned PARK_COORD_DEFAULT = 32'h0000_F000;

endpackage

// File: rtl/cursor_overlay_regs.sv
module cursor_overlay_regs
   import cursor_overlay_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 32,
   parameter int COORD_W       = 16,
   parameter int ROWS          = 32,
   parameter int POS_OFS       = 'h8FC,
   parameter int MASK_BASE     = 'h900,
   parameter int BITS_BASE     = 'h980,
   parameter int MISC_OFS      = 'h818,
   parameter int MISC_FORCE    = 25,
   parameter int PARK_COORD    = PARK_COORD_DEFAULT,
   parameter bit DEFER_UPDATE  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic                         frame_start,
   output logic [DATA_W-1:0]            rd_data,
   output logic [COORD_W-1:0]           cur_x,
   output logic [COORD_W-1:0]           cur_y,
   output logic [ROWS-1:0][DATA_W-1:0]  mask_rows,
   output logic [ROWS-1:0][DATA_W-1:0]  bits_rows
);

   localparam int ROW_W      = $clog2(ROWS);
   localparam int SPAN_BYTES = ROWS * 4;
   localparam int X_LSB      = DATA_W / 2;

   // Address decode: offsets below a base wrap to large values and miss
   logic [ADDR_W-1:0] mask_ofs, bits_ofs;
   logic              hit_pos, hit_misc, hit_mask, hit_bits;
   logic [ROW_W-1:0]  mask_idx, bits_idx;

   assign mask_ofs = addr - ADDR_W'(MASK_BASE);
   assign bits_ofs = addr - ADDR_W'(BITS_BASE);
   assign hit_pos  = (addr == ADDR_W'(POS_OFS));
   assign hit_misc = (addr == ADDR_W'(MISC_OFS));
   assign hit_mask = (mask_ofs < ADDR_W'(SPAN_BYTES));
   assign hit_bits = (bits_ofs < ADDR_W'(SPAN_BYTES));
   assign mask_idx = mask_ofs[ROW_W+1:2];
   assign bits_idx = bits_ofs[ROW_W+1:2];

   // Staged (software-visible) cursor state
   logic [COORD_W-1:0]          stg_x, stg_y;
   logic [ROWS-1:0][DATA_W-1:0] stg_mask, stg_bits;
   logic [DATA_W-1:0]           misc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_x    <= COORD_W'(PARK_COORD);
         stg_y    <= COORD_W'(PARK_COORD);
         stg_mask <= '0;
         stg_bits <= '0;
         misc_q   <= '0;
      end else if (wr_en) begin
         if (hit_pos) begin
            stg_x <= wdata[X_LSB +: COORD_W];
            stg_y <= wdata[0 +: COORD_W];
         end
         if (hit_mask) stg_mask[mask_idx] <= wdata;
         if (hit_bits) stg_bits[bits_idx] <= wdata;
         if (hit_misc) misc_q <= wdata;
      end
   end

   // Read path: misc with its fixed status bit, everything else reads zero
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         if (hit_misc) rd_data <= misc_q | (DATA_W'(1) << MISC_FORCE);
         else          rd_data <= '0;
      end
   end

   p_misc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit_misc) |=> rd_data[MISC_FORCE]);
   p_other_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit_misc) |=> (rd_data == '0));

   generate
      if (DEFER_UPDATE) begin : g_defer
         logic [COORD_W-1:0]          act_x, act_y;
         logic [ROWS-1:0][DATA_W-1:0] act_mask, act_bits;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_x    <= COORD_W'(PARK_COORD);
               act_y    <= COORD_W'(PARK_COORD);
               act_mask <= '0;
               act_bits <= '0;
            end else if (frame_start) begin
               act_x    <= stg_x;
               act_y    <= stg_y;
               act_mask <= stg_mask;
               act_bits <= stg_bits;
            end
         end

         assign cur_x     = act_x;
         assign cur_y     = act_y;
         assign mask_rows = act_mask;
         assign bits_rows = act_bits;

         p_hold_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_start |=> ($stable(act_x) && $stable(act_y)));
         p_hold_rows_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_start |=> ($stable(act_mask) && $stable(act_bits)));
      end else begin : g_direct
         assign cur_x     = stg_x;
         assign cur_y     = stg_y;
         assign mask_rows = stg_mask;
         assign bits_rows = stg_bits;
      end
   endgenerate

endmodule

// File: rtl/cursor_overlay_pixel.sv
module cursor_overlay_pixel
   import cursor_overlay_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int COORD_W = 16,
   parameter int COLOR_W = 24,
   parameter int ROWS    = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [COORD_W-1:0]           cur_x,
   input  logic [COORD_W-1:0]           cur_y,
   input  logic [ROWS-1:0][DATA_W-1:0]  mask_rows,
   input  logic [ROWS-1:0][DATA_W-1:0]  bits_rows,
   input  logic [COORD_W-1:0]           active_width,
   input  logic [COLOR_W-1:0]           col_a,
   input  logic [COLOR_W-1:0]           col_b,
   input  logic                         pix_valid,
   input  logic [COORD_W-1:0]           pix_x,
   input  logic [COORD_W-1:0]           pix_y,
   input  logic [COLOR_W-1:0]           pix_color,
   output logic                         out_valid,
   output logic [COORD_W-1:0]           out_x,
   output logic [COORD_W-1:0]           out_y,
   output logic [COLOR_W-1:0]           out_color
);

   localparam int ROW_W = $clog2(ROWS);
   localparam int COL_W = $clog2(DATA_W);

   // Offsets of the pixel from the cursor origin (wrap when left/above)
   logic [COORD_W-1:0] dx, dy;
   logic               row_hit, col_hit;
   logic [ROW_W-1:0]   row_sel;
   logic [COL_W-1:0]   bit_sel;
   logic [DATA_W-1:0]  mask_word, bits_word;
   logic               mask_bit, bits_bit;
   pix_src_e           src;
   logic [COLOR_W-1:0] next_color;

   assign dx = pix_x - cur_x;
   assign dy = pix_y - cur_y;

   assign row_hit = (pix_y >= cur_y) && (dy < COORD_W'(ROWS));
   assign col_hit = (pix_x >= cur_x) && (dx < COORD_W'(DATA_W))
                    && (cur_x < active_width) && (pix_x < active_width);

   // Leftmost cursor column uses the most significant bit
   assign row_sel   = dy[ROW_W-1:0];
   assign bit_sel   = COL_W'(DATA_W - 1) - dx[COL_W-1:0];
   assign mask_word = mask_rows[row_sel];
   assign bits_word = bits_rows[row_sel];
   assign mask_bit  = mask_word[bit_sel];
   assign bits_bit  = bits_word[bit_sel];

   always_comb begin
      if (row_hit && col_hit && mask_bit) src = bits_bit ? SRC_COL_B : SRC_COL_A;
      else                                src = SRC_BASE;
   end

   always_comb begin
      unique case (src)
         SRC_COL_A: next_color = col_a;
         SRC_COL_B: next_color = col_b;
         default:   next_color = pix_color;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_x     <= '0;
         out_y     <= '0;
         out_color <= '0;
      end else begin
         out_valid <= pix_valid;
         out_x     <= pix_x;
         out_y     <= pix_y;
         out_color <= next_color;
      end
   end

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);
   p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);
   p_coord_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (out_x == $past(pix_x) && out_y == $past(pix_y)));
   p_clip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_x >= active_width) |=> (out_color == $past(pix_color)));
   p_rows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !row_hit) |=> (out_color == $past(pix_color)));
   p_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && src == SRC_COL_B) |=> (out_color == $past(col_b)));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_overlay_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 32,
   parameter int COORD_W      = 16,
   parameter int COLOR_W      = 24,
   parameter int ROWS         = 32,
   parameter int POS_OFS      = 'h8FC,
   parameter int MASK_BASE    = 'h900,
   parameter int BITS_BASE    = 'h980,
   parameter int MISC_OFS     = 'h818,
   parameter int MISC_FORCE   = 25,
   parameter int PARK_COORD   = PARK_COORD_DEFAULT,
   parameter bit DEFER_UPDATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic                 reg_rd_en,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic                 frame_start,
   input  logic [COORD_W-1:0]   active_width,
   input  logic [COLOR_W-1:0]   col_a,
   input  logic [COLOR_W-1:0]   col_b,
   input  logic                 pix_valid,
   input  logic [COORD_W-1:0]   pix_x,
   input  logic [COORD_W-1:0]   pix_y,
   input  logic [COLOR_W-1:0]   pix_color,
   output logic                 out_valid,
   output logic [COORD_W-1:0]   out_x,
   output logic [COORD_W-1:0]   out_y,
   output logic [COLOR_W-1:0]   out_color
);

   localparam int SPAN_BYTES = ROWS * 4;

   // Elaboration-time parameter checks
   generate
      if (2 * COORD_W > DATA_W) begin : g_bad_coord
         $error("cursor_overlay: two coordinates must fit in one data word");
      end
      if ((ROWS & (ROWS - 1)) != 0 || ROWS < 2) begin : g_bad_rows
         $error("cursor_overlay: ROWS must be a power of two");
      end
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("cursor_overlay: DATA_W must be a power of two");
      end
      if (MISC_FORCE >= DATA_W) begin : g_bad_force
         $error("cursor_overlay: forced misc bit out of range");
      end
      if ((MASK_BASE % 4) != 0 || (BITS_BASE % 4) != 0) begin : g_bad_align
         $error("cursor_overlay: row bases must be word aligned");
      end
      if (!(BITS_BASE >= MASK_BASE + SPAN_BYTES || MASK_BASE >= BITS_BASE + SPAN_BYTES))
      begin : g_bad_overlap
         $error("cursor_overlay: row regions overlap");
      end
      if (PARK_COORD >= (1 << COORD_W)) begin : g_bad_park
         $error("cursor_overlay: park coordinate does not fit");
      end
   endgenerate

   logic [COORD_W-1:0]          cur_x, cur_y;
   logic [ROWS-1:0][DATA_W-1:0] mask_rows, bits_rows;

   cursor_overlay_regs #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .COORD_W      (COORD_W),
      .ROWS         (ROWS),
      .POS_OFS      (POS_OFS),
      .MASK_BASE    (MASK_BASE),
      .BITS_BASE    (BITS_BASE),
      .MISC_OFS     (MISC_OFS),
      .MISC_FORCE   (MISC_FORCE),
      .PARK_COORD   (PARK_COORD),
      .DEFER_UPDATE (DEFER_UPDATE)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en),
      .rd_en       (reg_rd_en),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .frame_start (frame_start),
      .rd_data     (reg_rdata),
      .cur_x       (cur_x),
      .cur_y       (cur_y),
      .mask_rows   (mask_rows),
      .bits_rows   (bits_rows)
   );

   cursor_overlay_pixel #(
      .DATA_W  (DATA_W),
      .COORD_W (COORD_W),
      .COLOR_W (COLOR_W),
      .ROWS    (ROWS)
   ) u_pixel (
      .clk          (clk),
      .rst_n        (rst_n),
      .cur_x        (cur_x),
      .cur_y        (cur_y),
      .mask_rows    (mask_rows),
      .bits_rows    (bits_rows),
      .active_width (active_width),
      .col_a        (col_a),
      .col_b        (col_b),
      .pix_valid    (pix_valid),
      .pix_x        (pix_x),
      .pix_y        (pix_y),
      .pix_color    (pix_color),
      .out_valid    (out_valid),
      .out_x        (out_x),
      .out_y        (out_y),
      .out_color    (out_color)
   );

   p_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cur_x == COORD_W'(PARK_COORD) && cur_y == COORD_W'(PARK_COORD)));

endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

   localparam int SCR_W  = 64;
   localparam int SCR_H  = 40;
   localparam int ACT_W  = 48;
   localparam logic [23:0] COLA = 24'hA0_A0_A0;
   localparam logic [23:0] COLB = 24'h0B_0B_0B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        frame_start = 1'b0;
   logic [15:0] active_width = 16'(ACT_W);
   logic [23:0] col_a = COLA, col_b = COLB;
   logic        pix_valid = 1'b0;
   logic [15:0] pix_x = '0, pix_y = '0;
   logic [23:0] pix_color = '0;
   logic        out_valid;
   logic [15:0] out_x, out_y;
   logic [23:0] out_color;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Bench model of the committed cursor state
   logic [31:0] m_mask [32];
   logic [31:0] m_bits [32];
   logic [31:0] s_mask [32];
   logic [31:0] s_bits [32];
   int m_cx = 'hF000, m_cy = 'hF000;
   int s_cx = 'hF000, s_cy = 'hF000;

   always #4 clk = ~clk;

   cursor_overlay u_cursor_overlay (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
      .active_width(active_width), .col_a(col_a), .col_b(col_b),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color),
      .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_color(out_color)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] base_of(input int x, input int y);
      return {8'(x), 8'(y), 8'h5A};
   endfunction

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
      if (a == 12'h8FC) begin s_cx = int'(d[31:16]); s_cy = int'(d[15:0]); end
      if (a >= 12'h900 && a < 12'h980) s_mask[(a - 12'h900) >> 2] = d;
      if (a >= 12'h980 && a < 12'hA00) s_bits[(a - 12'h980) >> 2] = d;
   endtask

   task automatic reg_read(input logic [11:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a; reg_rd_en = 1'b1;
      @(posedge clk); #1;
      check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   task automatic commit_frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      m_cx = s_cx; m_cy = s_cy;
      for (int r = 0; r < 32; r++) begin m_mask[r] = s_mask[r]; m_bits[r] = s_bits[r]; end
   endtask

   // Drive one pixel; check the registered result one edge later
   task automatic send_pixel(input int x, input int y, input bit v, input string phase);
      logic [23:0] exp;
      string tag;
      @(negedge clk);
      pix_valid = v; pix_x = 16'(x); pix_y = 16'(y); pix_color = base_of(x, y);
      exp = base_of(x, y);
      tag = "R6 outside rows";
      if (m_cx >= ACT_W || x >= ACT_W) tag = "R7 width clip";
      else if (y >= m_cy && y < m_cy + 32) begin
         tag = "R6 row window";
         if (x >= m_cx && x < m_cx + 32) begin
            int r = y - m_cy;
            int b = 31 - (x - m_cx);
            tag = "R3 R4 R5 shape";
            if (m_mask[r][b]) exp = m_bits[r][b] ? COLB : COLA;
         end
      end
      @(posedge clk); #1;
      if (!v) begin
         check(out_valid == 1'b0, {"R9 bubble ", phase}, 64'(out_valid), 64'd0);
      end else begin
         check(out_valid && out_x == 16'(x) && out_y == 16'(y) && out_color == exp,
               {tag, " ", phase},
               {7'd0, out_valid, out_x, out_y, out_color},
               {7'd0, 1'b1, 16'(x), 16'(y), exp});
      end
   endtask

   task automatic sweep(input string phase);
      int n = 0;
      for (int y = 0; y < SCR_H; y++) begin
         for (int x = 0; x < SCR_W; x++) begin
            send_pixel(x, y, 1'b1, phase);
            n++;
            if (n % 37 == 0) send_pixel(x, y, 1'b0, phase);
         end
      end
      @(negedge clk);
      pix_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 32; r++) begin
         m_mask[r] = '0; m_bits[r] = '0; s_mask[r] = '0; s_bits[r] = '0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state of the outputs
      check(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);
      check(reg_rdata == 32'd0, "R1 reset rdata", 64'(reg_rdata), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8: misc read after reset, write, other offsets
      reg_read(12'h818, 32'h0200_0000, "R8 misc reset");
      reg_write(12'h818, 32'h00A0_00FF);
      reg_read(12'h818, 32'h02A0_00FF, "R8 misc forced bit");
      reg_write(12'h818, 32'hFFFF_FFFF);
      reg_read(12'h818, 32'hFFFF_FFFF, "R8 misc all ones");

      // R1: parked cursor draws nothing even after a commit
      commit_frame();
      sweep("R1 parked");

      // R3: program row words with distinct patterns, R2: position 20,5
      for (int r = 0; r < 32; r++) begin
         logic [31:0] mv = 32'h9E37_79B9 * 32'(r + 1);
         logic [31:0] bv = 32'h7F4A_7C15 * 32'(r + 3);
         if (r == 0) mv = 32'hFFFF_FFFF;
         reg_write(12'h900 + 12'(4 * r), mv);
         reg_write(12'h980 + 12'(4 * r), bv);
      end
      reg_write(12'h8FC, {16'd20, 16'd5});
      reg_read(12'h8FC, 32'd0, "R8 position reads zero");
      reg_read(12'h900, 32'd0, "R8 mask row reads zero");

      // R10: staged writes invisible until the frame start
      sweep("R10 before commit");
      commit_frame();
      sweep("R2 position 20,5");

      // R6/R7: cursor crossing right clip edge and bottom of screen
      reg_write(12'h8FC, {16'd40, 16'd30});
      commit_frame();
      sweep("R2 position 40,30");

      // R7: cursor origin at or beyond active width draws nothing
      reg_write(12'h8FC, {16'd48, 16'd2});
      commit_frame();
      sweep("R7 origin at width");

      // R3: rewrite last mask row and first colour row, corner placement
      reg_write(12'h97C, 32'hFFFF_FFFF);
      reg_write(12'h980, 32'hAAAA_5555);
      reg_write(12'h8FC, {16'd0, 16'd0});
      commit_frame();
      sweep("R3 corner 0,0");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule